// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a register of `WIDTH` bits (eight by default) that changes only on the rising clock edge. On each edge it holds, shifts towards the high end, shifts towards the low end, loads a word from a shared parallel bus, or clears to zero. A two-bit mode code selects the operation. An active-low synchronous clear overrides the mode code. The contents are undefined after power-up until the first clear or load.

The parallel bus is modelled as three signals: a bus input, a data-out vector and a drive-enable. The data-out vector always carries the current contents. The drive-enable tells the pad logic when to put them on the bus. Load mode releases the drive by itself, so that external data can be sampled. Either of two active-low enables can also release it without stopping the register.

The lowest and highest bits are available at all times on their own serial outputs. Several blocks can be chained into a longer register by wiring each end output to the neighbour's serial input.

Top module: `ushift_bus_reg`

## Requirements
- R1: Mode code 2'b00 (hold) keeps every bit unchanged across a rising clock edge.
- R2: Mode code 2'b01 (shift up) takes `ser_in_up` into bit 0 and moves bit i into bit i+1 at the edge; the old top bit is discarded.
- R3: Mode code 2'b10 (shift down) takes `ser_in_dn` into the top bit and moves bit i into bit i-1 at the edge; the old bit 0 is discarded.
- R4: Mode code 2'b11 (load) stores the value present on `bus_in` at the edge.
- R5: When `clr_n` is 0 at a rising edge, every bit becomes 0 after that edge, whatever the mode code.
- R6: When `oe_a_n` or `oe_b_n` is 1, `bus_drv` is 0, and hold, shift, load and clear still act on the register.
- R7: `bus_drv` is 0 while the mode code is 2'b11. It is 1 when both enables are 0 and the mode code is not 2'b11. `bus_out` carries the current contents.
- R8: `ser_out_lo` equals bit 0 and `ser_out_hi` equals the top bit at all times, independent of the output enables.
- R9: `clr_n`, the mode code and `bus_in` have no effect between clock edges.
- R10: Two blocks chained through their serial ports (low block's `ser_out_hi` to high block's `ser_in_up`, high block's `ser_out_lo` to low block's `ser_in_dn`) shift as one register of twice the width, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, overrides the mode code |
| mode | input | 2 | Operation code: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_up | input | 1 | Serial data entering bit 0 when shifting up |
| ser_in_dn | input | 1 | Serial data entering the top bit when shifting down |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| bus_in | input | WIDTH | Value read from the shared bus |
| bus_out | output | WIDTH | Register contents, for the bus drivers |
| bus_drv | output | 1 | Bus drive-enable; 0 means high impedance |
| ser_out_lo | output | 1 | Bit 0, always valid |
| ser_out_hi | output | 1 | Top bit, always valid |

## Verification
Once the first clear has been seen, the bound checker checks on every cycle the effect of each mode code, the priority of the clear, the drive-enable rules and the serial taps. The absence of any effect between clock edges cannot be seen by properties sampled at the edge, so a directed scenario toggles clear and the mode code mid-cycle and observes the outputs. Chaining two blocks into a double-width register is also a bench scenario only, because it involves two instances and the wiring between them.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
   typedef enum logic [1:0] {
      M_HOLD = 2'b00,
      M_UP   = 2'b01,
      M_DN   = 2'b10,
      M_LOAD = 2'b11
   } mode_e;
endpackage

// File: rtl/ushift_next.sv
// Per-bit next-state selection; clear priority is handled in ushift_store.
module ushift_next #(
   parameter int WIDTH = 8
) (
   input  logic [1:0]       mode,
   input  logic             ser_in_up,
   input  logic             ser_in_dn,
   input  logic [WIDTH-1:0] q,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] d
);
   import ushift_pkg::*;

   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_below;
      logic from_above;

      if (i == 0) begin : g_lo_edge
         assign from_below = ser_in_up;
      end else begin : g_lo_mid
         assign from_below = q[i-1];
      end

      if (i == TOP) begin : g_hi_edge
         assign from_above = ser_in_dn;
      end else begin : g_hi_mid
         assign from_above = q[i+1];
      end

      always_comb begin
         unique case (mode_e'(mode))
            M_HOLD:  d[i] = q[i];
            M_UP:    d[i] = from_below;
            M_DN:    d[i] = from_above;
            M_LOAD:  d[i] = bus_in[i];
            default: d[i] = q[i];
         endcase
      end
   end
endmodule

// File: rtl/ushift_store.sv
// State register, synchronous clear, no power-on reset.
module ushift_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (!clr_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/ushift_drive.sv
// Bus drive-enable and end-bit taps.
module ushift_drive #(
   parameter int WIDTH = 8
) (
   input  logic [1:0]       mode,
   input  logic             oe_a_n,
   input  logic             oe_b_n,
   input  logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_drv,
   output logic             ser_out_lo,
   output logic             ser_out_hi
);
   import ushift_pkg::*;

   logic enables_ok;
   logic load_sel;

   assign enables_ok = ~(oe_a_n | oe_b_n);
   assign load_sel   = (mode_e'(mode) == M_LOAD);
   assign bus_drv    = enables_ok & ~load_sel;
   assign bus_out    = q;
   assign ser_out_lo = q[0];
   assign ser_out_hi = q[WIDTH-1];
endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [1:0]       mode,
   input  logic             ser_in_up,
   input  logic             ser_in_dn,
   input  logic             oe_a_n,
   input  logic             oe_b_n,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_drv,
   output logic             ser_out_lo,
   output logic             ser_out_hi
);
   if (WIDTH < 2) begin : g_bad_width
      $error("ushift_bus_reg: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] d;

   ushift_next #(.WIDTH(WIDTH)) u_next (
      .mode      (mode),
      .ser_in_up (ser_in_up),
      .ser_in_dn (ser_in_dn),
      .q         (q),
      .bus_in    (bus_in),
      .d         (d)
   );

   ushift_store #(.WIDTH(WIDTH)) u_store (
      .clk   (clk),
      .clr_n (clr_n),
      .d     (d),
      .q     (q)
   );

   ushift_drive #(.WIDTH(WIDTH)) u_drive (
      .mode       (mode),
      .oe_a_n     (oe_a_n),
      .oe_b_n     (oe_b_n),
      .q          (q),
      .bus_out    (bus_out),
      .bus_drv    (bus_drv),
      .ser_out_lo (ser_out_lo),
      .ser_out_hi (ser_out_hi)
   );
endmodule

// File: rtl/ushift_bus_reg_chk.sv
module ushift_bus_reg_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             clr_n,
   input logic [1:0]       mode,
   input logic             ser_in_up,
   input logic             ser_in_dn,
   input logic             oe_a_n,
   input logic             oe_b_n,
   input logic [WIDTH-1:0] bus_in,
   input logic [WIDTH-1:0] bus_out,
   input logic             bus_drv,
   input logic             ser_out_lo,
   input logic             ser_out_hi
);
   // Contents are undefined until the first clear; checks start after it.
   logic primed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n) primed <= 1'b1;
   end

   a_r1_hold: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && mode == 2'b00) |=> $stable(bus_out));

   a_r2_shift_up: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && mode == 2'b01) |=>
         bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_in_up)});

   a_r3_shift_dn: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && mode == 2'b10) |=>
         bus_out == {$past(ser_in_dn), $past(bus_out[WIDTH-1:1])});

   a_r4_load: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && mode == 2'b11) |=> bus_out == $past(bus_in));

   a_r5_clear: assert property (@(posedge clk) disable iff (!primed)
      !clr_n |=> bus_out == '0);

   a_r6_enables_off: assert property (@(posedge clk) disable iff (!primed)
      (oe_a_n || oe_b_n) |-> !bus_drv);

   a_r7_load_releases: assert property (@(posedge clk) disable iff (!primed)
      (mode == 2'b11) |-> !bus_drv);

   a_r7_drive_on: assert property (@(posedge clk) disable iff (!primed)
      (!oe_a_n && !oe_b_n && mode != 2'b11) |-> bus_drv);

   a_r8_taps: assert property (@(posedge clk) disable iff (!primed)
      (ser_out_lo == bus_out[0]) && (ser_out_hi == bus_out[WIDTH-1]));
endmodule

bind ushift_bus_reg ushift_bus_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_ushift_bus_reg.sv
module test_ushift_bus_reg;
   localparam int W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         clr_n = 1'b1;
   logic [1:0]   mode = 2'b00;
   logic         sin_up = 1'b0, sin_dn = 1'b0, oea = 1'b0, oeb = 1'b0;
   logic [W-1:0] bin = '0;
   logic [W-1:0] bout;
   logic         drv, s_lo, s_hi;

   ushift_bus_reg #(.WIDTH(W)) i_ushift_bus_reg (
      .clk(clk), .clr_n(clr_n), .mode(mode), .ser_in_up(sin_up),
      .ser_in_dn(sin_dn), .oe_a_n(oea), .oe_b_n(oeb), .bus_in(bin),
      .bus_out(bout), .bus_drv(drv), .ser_out_lo(s_lo), .ser_out_hi(s_hi));

   // Chained pair for R10
   logic         c_clr_n = 1'b1;
   logic [1:0]   c_mode = 2'b00;
   logic         c_up_in = 1'b0, c_dn_in = 1'b0;
   logic [W-1:0] c_bin_lo = '0, c_bin_hi = '0;
   logic [W-1:0] c_out_lo, c_out_hi;
   logic         lo_to_hi, hi_to_lo, lo_lo_tap, hi_hi_tap, c_drv_lo, c_drv_hi;

   ushift_bus_reg #(.WIDTH(W)) i_ushift_bus_reg_clo (
      .clk(clk), .clr_n(c_clr_n), .mode(c_mode), .ser_in_up(c_up_in),
      .ser_in_dn(hi_to_lo), .oe_a_n(1'b0), .oe_b_n(1'b0), .bus_in(c_bin_lo),
      .bus_out(c_out_lo), .bus_drv(c_drv_lo), .ser_out_lo(lo_lo_tap),
      .ser_out_hi(lo_to_hi));

   ushift_bus_reg #(.WIDTH(W)) i_ushift_bus_reg_chi (
      .clk(clk), .clr_n(c_clr_n), .mode(c_mode), .ser_in_up(lo_to_hi),
      .ser_in_dn(c_dn_in), .oe_a_n(1'b0), .oe_b_n(1'b0), .bus_in(c_bin_hi),
      .bus_out(c_out_hi), .bus_drv(c_drv_hi), .ser_out_lo(hi_to_lo),
      .ser_out_hi(hi_hi_tap));

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic         clr;
      logic [1:0]   md;
      logic         up;
      logic         dn;
      logic         oa;
      logic         ob;
      logic [W-1:0] bi;
      logic [W-1:0] q;
      logic         dr;
   } vec_t;

   // Inputs applied before an edge; q is the contents after it, dr the drive-enable.
   localparam vec_t TBL [0:11] = '{
      '{1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b0}, // R5 clear beats load
      '{1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0}, // R4 R7
      '{1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hA5, 1'b1}, // R1 R7
      '{1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h4B, 1'b1}, // R2
      '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h96, 1'b1}, // R2
      '{1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hCB, 1'b0}, // R3 R6
      '{1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h65, 1'b0}, // R3 R6
      '{1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0}, // R4
      '{1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R5 clear beats shift
      '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R5
      '{1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 8'h81, 1'b0}, // R6 load while disabled
      '{1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h81, 1'b1}  // R1
   };

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [2*W-1:0] model;
      logic [4:0] pat;

      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         clr_n = TBL[k].clr; mode = TBL[k].md; sin_up = TBL[k].up; sin_dn = TBL[k].dn;
         oea = TBL[k].oa; oeb = TBL[k].ob; bin = TBL[k].bi;
         @(posedge clk); #1;
         check("R1-R5 contents", {8'h00, bout}, {8'h00, TBL[k].q});
         check("R6/R7 bus_drv", {15'h0, drv}, {15'h0, TBL[k].dr});
         check("R8 taps", {14'h0, s_hi, s_lo}, {14'h0, TBL[k].q[W-1], TBL[k].q[0]});
      end

      // R9: clear and load requested between edges, withdrawn before the edge
      @(negedge clk);
      clr_n = 1'b0; mode = 2'b11; bin = 8'h00;
      #1;
      check("R9 mid-cycle no effect", {8'h00, bout}, 16'h0081);
      clr_n = 1'b1; mode = 2'b00;
      @(posedge clk); #1;
      check("R9 after edge", {8'h00, bout}, 16'h0081);

      // R6: enables off, shift and clear still act; taps still follow (R8)
      @(negedge clk);
      oea = 1'b1; oeb = 1'b1; mode = 2'b10; sin_dn = 1'b1;
      @(posedge clk); #1;
      check("R6 shift while disabled", {8'h00, bout}, 16'h00C0);
      check("R8 taps while disabled", {14'h0, s_hi, s_lo}, 16'h0002);
      check("R6 drive off", {15'h0, drv}, 16'h0000);

      // R10: chained pair, double-width shifts
      @(negedge clk);
      c_clr_n = 1'b0;
      @(negedge clk);
      c_clr_n = 1'b1; c_mode = 2'b11; c_bin_lo = 8'h5A; c_bin_hi = 8'hC3;
      @(posedge clk); #1;
      model = 16'hC35A;
      check("R10 load pair", {c_out_hi, c_out_lo}, model);
      pat = 5'b10110;
      for (int s = 0; s < 5; s++) begin
         @(negedge clk);
         c_mode = 2'b01; c_up_in = pat[s];
         @(posedge clk); #1;
         model = {model[2*W-2:0], pat[s]};
         check("R10 chained shift up", {c_out_hi, c_out_lo}, model);
      end
      for (int s = 0; s < 5; s++) begin
         @(negedge clk);
         c_mode = 2'b10; c_dn_in = ~pat[s];
         @(posedge clk); #1;
         model = {~pat[s], model[2*W-1:1]};
         check("R10 chained shift down", {c_out_hi, c_out_lo}, model);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule